// File: doc/BRIEF.md
# DRAM Bank Timing State Tracker

This block keeps the per-bank state of a single DRAM rank and tells a command scheduler whether a proposed command may go out in the current cycle. For every bank it holds an idle or row-open flag, the address of the open row, a count of column accesses made to that row, and four earliest-allowed times: one each for opening a row, reading, writing and closing the row. A free-running cycle counter supplies the current time. All of these timing windows are parameters.

The scheduler presents a command type, bank and row on every cycle. The block answers at once with a combinational `issuable` flag. When the scheduler also raises `cmdValid`, the command counts as sent. A legal command then updates the timing state of its own bank and, for column commands and row opens, the state of the other banks too. A command sent while it is not legal changes no state. Instead it sets a sticky `protoErr` output. Posted column access is modelled by taking the additive latency off the row-to-column delay.

Top module: `dram_bank_timer`

## Requirements
- R1: After reset every bank is idle, every earliest-allowed time is zero, the cycle counter starts from zero and `protoErr` is low; a row open (code 0) is issuable to any bank at once and no column command is.
- R2: A row open (`cmdType` 0) is issuable only when the addressed bank is idle and the current time has reached that bank's row-open time; code 7 is never issuable.
- R3: An accepted row open marks the bank open with the given row. It sets the bank's row-open time to now+T_RC, its read and write times to now+(T_RCD−T_AL), its close time to now+T_RAS, and clears its access count.
- R4: An accepted row open raises the row-open time of every other bank to at least now+T_RRD.
- R5: A read (code 1, or 2 with auto-close) or write (code 3, or 4 with auto-close) is issuable only if the bank is open, the row equals the open row and the read or write time has been reached.
- R6: An accepted read raises the bank's close time to at least now+T_RTP. In every bank it raises the read time to at least now+max(T_CCD, T_BL/2) and the write time to at least now+T_RTW.
- R7: An accepted write raises the bank's close time to at least now+T_WTP. In every bank it raises the write time to at least now+max(T_CCD, T_BL/2) and the read time to at least now+T_WTR.
- R8: An accepted read with auto-close (code 2) or write with auto-close (code 4) makes the same all-bank updates as a plain read or write. It returns the bank to idle and raises its row-open time to at least now+T_RDAP or now+T_WRAP respectively.
- R9: A close (code 5) is issuable only when the bank is open and its close time is reached. Accepting it idles the bank and raises its row-open time to at least now+T_RP.
- R10: A refresh (code 6) is issuable only when every bank is idle. Accepting it sets every bank's row-open time to now+T_RFC.
- R11: Reads and writes to a bank are blocked once that bank has taken MAX_ROW_ACC column accesses since its row was opened.
- R12: A command accepted while not issuable sets `protoErr`, which stays high until reset, and leaves all bank state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | The presented command is being sent this cycle |
| cmdType | input | 3 | Command code (0 open, 1 read, 2 read+close, 3 write, 4 write+close, 5 close, 6 refresh, 7 none) |
| cmdBank | input | BANK_W | Target bank |
| cmdRow | input | ROW_W | Target row |
| issuable | output | 1 | The presented command is legal in this cycle |
| protoErr | output | 1 | Sticky flag: an illegal command was sent |

## Verification
Two functions meet on one clock edge: the legality decision for a command and the state update that the same command makes. A command that lands exactly on the first legal cycle of its window therefore sets new windows for the next cycle. The bench provokes this by polling each command with `cmdValid` low until a requirement-based model says it becomes legal, then sending it in that very cycle. The cycle before it must read not issuable, the send cycle must read issuable, and the following queries must reflect the new windows. A second pairing is an illegal send against the sticky error. The bench judges it by showing that `protoErr` rises on the next cycle while the bank state seen through `issuable` is unchanged.

// File: rtl/dram_trk_pkg.sv
package dram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_ACT = 3'd0,
    CMD_RD  = 3'd1,
    CMD_RDA = 3'd2,
    CMD_WR  = 3'd3,
    CMD_WRA = 3'd4,
    CMD_PRE = 3'd5,
    CMD_REF = 3'd6,
    CMD_NOP = 3'd7
  } cmd_e;

  // One-hot strobes from control to datapath; doAuto qualifies doRd/doWr.
  typedef struct packed {
    logic doAct;
    logic doRd;
    logic doWr;
    logic doAuto;
    logic doPre;
    logic doRef;
  } strobe_t;

endpackage

// File: rtl/trk_ctrl.sv
module trk_ctrl
  import dram_trk_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic [2:0]                 cmdType,
  input  logic [BANK_W-1:0]          cmdBank,
  input  logic [ROW_W-1:0]           cmdRow,
  input  logic [NB-1:0]              bankActive,
  input  logic [NB-1:0][ROW_W-1:0]   openRow,
  input  logic [NB-1:0]              actReady,
  input  logic [NB-1:0]              rdReady,
  input  logic [NB-1:0]              wrReady,
  input  logic [NB-1:0]              preReady,
  input  logic [NB-1:0]              accFull,
  output logic                       issuable,
  output strobe_t                    strobes,
  output logic                       protoErr
);

  cmd_e op;
  logic selActive;
  logic rowHit;
  logic colOk;
  logic accept;

  assign op        = cmd_e'(cmdType);
  assign selActive = bankActive[cmdBank];
  assign rowHit    = (openRow[cmdBank] == cmdRow);
  assign colOk     = selActive && rowHit && !accFull[cmdBank];

  always_comb begin
    unique case (op)
      CMD_ACT:          issuable = !selActive && actReady[cmdBank];
      CMD_RD, CMD_RDA:  issuable = colOk && rdReady[cmdBank];
      CMD_WR, CMD_WRA:  issuable = colOk && wrReady[cmdBank];
      CMD_PRE:          issuable = selActive && preReady[cmdBank];
      CMD_REF:          issuable = (bankActive == '0);
      default:          issuable = 1'b0;
    endcase
  end

  assign accept = cmdValid && issuable;

  always_comb begin
    strobes        = '0;
    strobes.doAct  = accept && (op == CMD_ACT);
    strobes.doRd   = accept && ((op == CMD_RD) || (op == CMD_RDA));
    strobes.doWr   = accept && ((op == CMD_WR) || (op == CMD_WRA));
    strobes.doAuto = accept && ((op == CMD_RDA) || (op == CMD_WRA));
    strobes.doPre  = accept && (op == CMD_PRE);
    strobes.doRef  = accept && (op == CMD_REF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) protoErr <= 1'b0;
    else if (cmdValid && !issuable) protoErr <= 1'b1;
  end

endmodule

// File: rtl/trk_dp.sv
module trk_dp
  import dram_trk_pkg::*;
#(
  parameter int NB          = 4,
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 8,
  parameter int CNT_W       = 20,
  parameter int T_RC        = 10,
  parameter int T_RCD       = 4,
  parameter int T_AL        = 1,
  parameter int T_RAS       = 7,
  parameter int T_RRD       = 2,
  parameter int T_CCD       = 2,
  parameter int T_BL        = 8,
  parameter int T_RTP       = 3,
  parameter int T_RTW       = 5,
  parameter int T_WTP       = 6,
  parameter int T_WTR       = 4,
  parameter int T_RDAP      = 8,
  parameter int T_WRAP      = 9,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 12,
  parameter int MAX_ROW_ACC = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobes,
  input  logic [BANK_W-1:0]         selBank,
  input  logic [ROW_W-1:0]          selRow,
  output logic [NB-1:0]             bankActive,
  output logic [NB-1:0][ROW_W-1:0]  openRow,
  output logic [NB-1:0]             actReady,
  output logic [NB-1:0]             rdReady,
  output logic [NB-1:0]             wrReady,
  output logic [NB-1:0]             preReady,
  output logic [NB-1:0]             accFull
);

  localparam int ACC_W  = $clog2(MAX_ROW_ACC + 1);
  localparam int CCD_EF = (T_CCD > T_BL / 2) ? T_CCD : T_BL / 2;
  localparam logic [CNT_W-1:0] D_RC   = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] D_RCD  = CNT_W'(T_RCD - T_AL);
  localparam logic [CNT_W-1:0] D_RAS  = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] D_RRD  = CNT_W'(T_RRD);
  localparam logic [CNT_W-1:0] D_CCD  = CNT_W'(CCD_EF);
  localparam logic [CNT_W-1:0] D_RTP  = CNT_W'(T_RTP);
  localparam logic [CNT_W-1:0] D_RTW  = CNT_W'(T_RTW);
  localparam logic [CNT_W-1:0] D_WTP  = CNT_W'(T_WTP);
  localparam logic [CNT_W-1:0] D_WTR  = CNT_W'(T_WTR);
  localparam logic [CNT_W-1:0] D_RDAP = CNT_W'(T_RDAP);
  localparam logic [CNT_W-1:0] D_WRAP = CNT_W'(T_WRAP);
  localparam logic [CNT_W-1:0] D_RP   = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] D_RFC  = CNT_W'(T_RFC);
  localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(MAX_ROW_ACC);

  function automatic logic [CNT_W-1:0] maxT(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CNT_W-1:0] nowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) nowCnt <= '0;
    else       nowCnt <= nowCnt + CNT_W'(1);
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic             active;
    logic [ROW_W-1:0] rowQ;
    logic [CNT_W-1:0] nAct, nRd, nWr, nPre;
    logic [ACC_W-1:0] accCnt;
    logic             hit;

    assign hit = (selBank == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        active <= 1'b0;
        rowQ   <= '0;
        nAct   <= '0;
        nRd    <= '0;
        nWr    <= '0;
        nPre   <= '0;
        accCnt <= '0;
      end else begin
        if (strobes.doAct) begin
          if (hit) begin
            active <= 1'b1;
            rowQ   <= selRow;
            nAct   <= nowCnt + D_RC;
            nRd    <= nowCnt + D_RCD;
            nWr    <= nowCnt + D_RCD;
            nPre   <= nowCnt + D_RAS;
            accCnt <= '0;
          end else begin
            nAct <= maxT(nAct, nowCnt + D_RRD);
          end
        end
        if (strobes.doRd) begin
          nRd <= maxT(nRd, nowCnt + D_CCD);
          nWr <= maxT(nWr, nowCnt + D_RTW);
          if (hit) begin
            accCnt <= accCnt + ACC_W'(1);
            if (strobes.doAuto) begin
              active <= 1'b0;
              nAct   <= maxT(nAct, nowCnt + D_RDAP);
            end else begin
              nPre <= maxT(nPre, nowCnt + D_RTP);
            end
          end
        end
        if (strobes.doWr) begin
          nWr <= maxT(nWr, nowCnt + D_CCD);
          nRd <= maxT(nRd, nowCnt + D_WTR);
          if (hit) begin
            accCnt <= accCnt + ACC_W'(1);
            if (strobes.doAuto) begin
              active <= 1'b0;
              nAct   <= maxT(nAct, nowCnt + D_WRAP);
            end else begin
              nPre <= maxT(nPre, nowCnt + D_WTP);
            end
          end
        end
        if (strobes.doPre && hit) begin
          active <= 1'b0;
          nAct   <= maxT(nAct, nowCnt + D_RP);
        end
        if (strobes.doRef) begin
          nAct <= nowCnt + D_RFC;
        end
      end
    end

    assign bankActive[g] = active;
    assign openRow[g]    = rowQ;
    assign actReady[g]   = (nowCnt >= nAct);
    assign rdReady[g]    = (nowCnt >= nRd);
    assign wrReady[g]    = (nowCnt >= nWr);
    assign preReady[g]   = (nowCnt >= nPre);
    assign accFull[g]    = (accCnt >= ACC_MAX);
  end

endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
  import dram_trk_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 8,
  parameter int CNT_W       = 20,
  parameter int T_RC        = 10,
  parameter int T_RCD       = 4,
  parameter int T_AL        = 1,
  parameter int T_RAS       = 7,
  parameter int T_RRD       = 2,
  parameter int T_CCD       = 2,
  parameter int T_BL        = 8,
  parameter int T_RTP       = 3,
  parameter int T_RTW       = 5,
  parameter int T_WTP       = 6,
  parameter int T_WTR       = 4,
  parameter int T_RDAP      = 8,
  parameter int T_WRAP      = 9,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 12,
  parameter int MAX_ROW_ACC = 3,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdType,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ROW_W-1:0]  cmdRow,
  output logic              issuable,
  output logic              protoErr
);

  strobe_t                        strobes;
  logic [NUM_BANKS-1:0]           bankActive;
  logic [NUM_BANKS-1:0][ROW_W-1:0] openRow;
  logic [NUM_BANKS-1:0]           actReady, rdReady, wrReady, preReady, accFull;

  trk_ctrl #(.NB(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .bankActive(bankActive),
    .openRow(openRow), .actReady(actReady), .rdReady(rdReady),
    .wrReady(wrReady), .preReady(preReady), .accFull(accFull),
    .issuable(issuable), .strobes(strobes), .protoErr(protoErr)
  );

  trk_dp #(
    .NB(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W),
    .T_RC(T_RC), .T_RCD(T_RCD), .T_AL(T_AL), .T_RAS(T_RAS), .T_RRD(T_RRD),
    .T_CCD(T_CCD), .T_BL(T_BL), .T_RTP(T_RTP), .T_RTW(T_RTW), .T_WTP(T_WTP),
    .T_WTR(T_WTR), .T_RDAP(T_RDAP), .T_WRAP(T_WRAP), .T_RP(T_RP),
    .T_RFC(T_RFC), .MAX_ROW_ACC(MAX_ROW_ACC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selBank(cmdBank),
    .selRow(cmdRow), .bankActive(bankActive), .openRow(openRow),
    .actReady(actReady), .rdReady(rdReady), .wrReady(wrReady),
    .preReady(preReady), .accFull(accFull)
  );

endmodule

// File: rtl/dram_bank_timer_chk.sv
module dram_bank_timer_chk #(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdValid,
  input logic [2:0]    cmdType,
  input logic [BW-1:0] cmdBank,
  input logic          issuable,
  input logic          protoErr,
  input logic [NB-1:0] bankActive
);

  logic sent;
  assign sent = cmdValid && issuable;

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R12
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !issuable) |=> protoErr);

  // R12
  err_no_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !issuable) |=> (bankActive == $past(bankActive)));

  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sent && cmdType == 3'd0) |=> bankActive[$past(cmdBank)]);

  // R2
  act_reopen_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sent && cmdType == 3'd0) |=>
      !(issuable && cmdType == 3'd0 && cmdBank == $past(cmdBank)));

  // R8
  auto_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sent && (cmdType == 3'd2 || cmdType == 3'd4)) |=> !bankActive[$past(cmdBank)]);

  // R9
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sent && cmdType == 3'd5) |=> !bankActive[$past(cmdBank)]);

  // R10
  ref_blocks_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sent && cmdType == 3'd6) |=> (bankActive == '0) && !(issuable && cmdType == 3'd0));

endmodule

bind dram_bank_timer dram_bank_timer_chk #(.NB(NUM_BANKS), .BW(BANK_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
  .cmdBank(cmdBank), .issuable(issuable), .protoErr(protoErr),
  .bankActive(bankActive)
);

// File: tb/dram_bank_timer_tb.sv
module dram_bank_timer_tb_top;

  localparam int NB = 4;
  localparam int RC = 10, RCDE = 3, RAS = 7, RRD = 2, CCDE = 4;
  localparam int RTP = 3, RTW = 5, WTP = 6, WTR = 4, RDAP = 8, WRAP = 9;
  localparam int RP = 3, RFC = 12, MAXACC = 3;

  localparam logic [2:0] OP_ACT = 3'd0, OP_RD = 3'd1, OP_RDA = 3'd2,
                         OP_WR = 3'd3, OP_WRA = 3'd4, OP_PRE = 3'd5,
                         OP_REF = 3'd6, OP_NOP = 3'd7;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdType = OP_NOP;
  logic [1:0] cmdBank = '0;
  logic [7:0] cmdRow = '0;
  logic       issuable, protoErr;

  always #4 clk = ~clk;

  dram_bank_timer dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .issuable(issuable), .protoErr(protoErr)
  );

  typedef struct {
    bit    iss;
    bit    err;
    string req;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Requirement-level model of the rank
  int tbNow;
  bit mAct[NB];
  int mRow[NB], mNAct[NB], mNRd[NB], mNWr[NB], mNPre[NB], mAcc[NB];
  bit mErr;

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit modelIss(logic [2:0] t, int b, int r);
    bit allIdle = 1;
    for (int i = 0; i < NB; i++) if (mAct[i]) allIdle = 0;
    case (t)
      OP_ACT: return !mAct[b] && tbNow >= mNAct[b];
      OP_RD, OP_RDA: return mAct[b] && mRow[b] == r && tbNow >= mNRd[b] && mAcc[b] < MAXACC;
      OP_WR, OP_WRA: return mAct[b] && mRow[b] == r && tbNow >= mNWr[b] && mAcc[b] < MAXACC;
      OP_PRE: return mAct[b] && tbNow >= mNPre[b];
      OP_REF: return allIdle;
      default: return 0;
    endcase
  endfunction

  task automatic modelApply(logic [2:0] t, int b, int r);
    case (t)
      OP_ACT: begin
        for (int i = 0; i < NB; i++) if (i != b) mNAct[i] = mx(mNAct[i], tbNow + RRD);
        mAct[b] = 1; mRow[b] = r; mNAct[b] = tbNow + RC;
        mNRd[b] = tbNow + RCDE; mNWr[b] = tbNow + RCDE; mNPre[b] = tbNow + RAS; mAcc[b] = 0;
      end
      OP_RD, OP_RDA: begin
        for (int i = 0; i < NB; i++) begin
          mNRd[i] = mx(mNRd[i], tbNow + CCDE);
          mNWr[i] = mx(mNWr[i], tbNow + RTW);
        end
        mAcc[b]++;
        if (t == OP_RDA) begin mAct[b] = 0; mNAct[b] = mx(mNAct[b], tbNow + RDAP); end
        else mNPre[b] = mx(mNPre[b], tbNow + RTP);
      end
      OP_WR, OP_WRA: begin
        for (int i = 0; i < NB; i++) begin
          mNWr[i] = mx(mNWr[i], tbNow + CCDE);
          mNRd[i] = mx(mNRd[i], tbNow + WTR);
        end
        mAcc[b]++;
        if (t == OP_WRA) begin mAct[b] = 0; mNAct[b] = mx(mNAct[b], tbNow + WRAP); end
        else mNPre[b] = mx(mNPre[b], tbNow + WTP);
      end
      OP_PRE: begin mAct[b] = 0; mNAct[b] = mx(mNAct[b], tbNow + RP); end
      OP_REF: for (int i = 0; i < NB; i++) mNAct[i] = tbNow + RFC;
      default: ;
    endcase
  endtask

  // Driver: one command per cycle, expected result pushed to the scoreboard
  task automatic step(logic [2:0] t, int b, int r, bit v, string req);
    item_t it;
    bit e;
    @(negedge clk);
    cmdType = t; cmdBank = 2'(b); cmdRow = 8'(r); cmdValid = v;
    e = modelIss(t, b, r);
    it.iss = e; it.err = mErr; it.req = req;
    expQ.push_back(it);
    if (v) begin
      if (e) modelApply(t, b, r);
      else mErr = 1;
    end
    tbNow++;
  endtask

  // Poll with cmdValid low until legal, then send in that first legal cycle
  task automatic waitSend(logic [2:0] t, int b, int r, string req);
    for (int k = 0; k < 60; k++) begin
      if (modelIss(t, b, r)) break;
      step(t, b, r, 0, req);
    end
    step(t, b, r, 1, req);
  endtask

  // Monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (issuable !== it.iss || protoErr !== it.err) begin
          failures++;
          $display("FAIL %s: issuable=%0b protoErr=%0b expected issuable=%0b protoErr=%0b at t=%0d",
                   it.req, issuable, protoErr, it.iss, it.err, tbNow);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic string tagFor(logic [2:0] t);
    case (t)
      OP_ACT: return "R2";
      OP_RD, OP_WR: return "R5";
      OP_RDA, OP_WRA: return "R8";
      OP_PRE: return "R9";
      OP_REF: return "R10";
      default: return "R2";
    endcase
  endfunction

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < NB; i++) begin
      mAct[i] = 0; mRow[i] = 0; mNAct[i] = 0; mNRd[i] = 0;
      mNWr[i] = 0; mNPre[i] = 0; mAcc[i] = 0;
    end
    mErr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tbNow = 1;

    // R1: reset state
    for (int b = 0; b < NB; b++) step(OP_ACT, b, 0, 0, "R1");
    step(OP_RD, 0, 0, 0, "R1");
    step(OP_WR, 1, 0, 0, "R1");
    step(OP_PRE, 2, 0, 0, "R1");
    step(OP_REF, 0, 0, 0, "R10");
    step(OP_NOP, 0, 0, 0, "R2");

    // R3, R4, R5: open bank 0 and check windows cycle by cycle
    step(OP_ACT, 0, 5, 1, "R3");
    step(OP_ACT, 1, 2, 0, "R4");
    step(OP_RD, 0, 5, 0, "R3");
    step(OP_RD, 0, 6, 0, "R5");
    waitSend(OP_RD, 0, 5, "R6");
    step(OP_ACT, 0, 5, 0, "R2");
    step(OP_WR, 0, 5, 0, "R6");
    step(OP_RD, 0, 5, 0, "R6");
    waitSend(OP_WR, 0, 5, "R7");
    step(OP_RD, 0, 5, 0, "R7");
    step(OP_PRE, 0, 0, 0, "R7");
    waitSend(OP_PRE, 0, 0, "R9");
    step(OP_ACT, 0, 7, 0, "R9");
    waitSend(OP_ACT, 0, 7, "R9");

    // R11: access cap on bank 1
    waitSend(OP_ACT, 1, 2, "R4");
    for (int k = 0; k < MAXACC; k++) waitSend(OP_RD, 1, 2, "R11");
    repeat (6) step(OP_RD, 1, 2, 0, "R11");
    step(OP_WR, 1, 2, 0, "R11");

    // R10: refresh needs all idle, then blocks opens for T_RFC
    step(OP_REF, 0, 0, 0, "R10");
    waitSend(OP_PRE, 0, 0, "R9");
    waitSend(OP_PRE, 1, 0, "R9");
    waitSend(OP_REF, 0, 0, "R10");
    step(OP_ACT, 2, 0, 0, "R10");
    waitSend(OP_ACT, 2, 0, "R10");

    // R8: auto-close variants
    waitSend(OP_RDA, 2, 0, "R8");
    step(OP_RD, 2, 0, 0, "R8");
    step(OP_ACT, 2, 1, 0, "R8");
    waitSend(OP_ACT, 2, 1, "R8");
    waitSend(OP_WRA, 2, 1, "R8");
    step(OP_WR, 2, 1, 0, "R8");
    waitSend(OP_ACT, 2, 3, "R8");

    // R12: illegal send sets sticky error, state untouched
    step(OP_PRE, 3, 0, 1, "R12");
    step(OP_PRE, 3, 0, 0, "R12");
    step(OP_ACT, 3, 0, 0, "R12");
    step(OP_RD, 3, 0, 1, "R12");
    step(OP_ACT, 3, 0, 0, "R12");

    // Mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] t;
      int b, r;
      bit v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      t = lfsr[2:0];
      b = int'(lfsr[4:3]);
      r = int'(lfsr[6:5]);
      v = modelIss(t, b, r) && (lfsr[7] | lfsr[8]);
      step(t, b, r, v, tagFor(t));
    end

    step(OP_NOP, 0, 0, 0, "R2");
    @(negedge clk);
    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule